// File: doc/BRIEF.md
# Dual-Memory Self-Test Sequencer with Reversible Full-Cycle Address Generator

This block runs a built-in self-test over two memories of the same size at once, for example an instruction store and a data store. One address bus drives both memories. The addresses come from a shift-register sequence generator. Its feedback is extended so that it visits every one of the 2^AW addresses, the all-zero word included. It can step forward or backward through that cycle, and the two directions trace the same cycle in opposite orders.

A run is started with a one-cycle `start` pulse. The block first writes every location, then reads every location back using the opposite stepping direction. The written word is `pattern` XOR the address. The two read-data buses are compared with each other, not with stored expected values. The first disagreement latches an error flag and records the address that produced it. When the last comparison has been made, `done` rises and stays high until the next run is started.

Top module: `dual_mem_bist`

## Requirements
- R1: After reset, `wr_en`, `rd_en`, `busy`, `done` and `err` are low, and `addr` and `err_addr` are zero.
- R2: A `start` sampled while the block is idle or done begins a write pass on the next cycle. The write pass holds `wr_en` high for exactly 2^AW consecutive cycles, and its first address is zero.
- R3: Stepping forward shifts the address one place toward bit 0 and feeds a new bit into the top bit. A full pass visits all 2^AW addresses exactly once. For AW=4 the forward order from zero is 0,8,C,E,F,7,B,5,A,D,6,3,9,4,2,1.
- R4: Stepping backward traverses the same cycle in reverse. For AW=4 the backward order from zero is 0,1,2,4,9,3,6,D,A,5,B,7,F,E,C,8.
- R5: With `rev_first`=0 (captured at start), the write pass steps forward and the read pass steps backward. With `rev_first`=1 the two directions are swapped. Each pass starts at address zero.
- R6: The read pass follows the write pass immediately. It holds `rd_en` high for exactly 2^AW consecutive cycles, and `wr_en` and `rd_en` are never high together.
- R7: During the write pass, `wr_data` equals `pattern` XOR the current address zero-extended to DW bits.
- R8: The two read-data buses are compared in the cycle after each read. The first inequality sets `err` and loads `err_addr` with the address of that read. Later inequalities change neither.
- R9: `done` rises one cycle after the last read cycle, which is 2·2^AW+1 cycles after the start edge. It then stays high with both strobes low and `addr` at zero until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored: the sequence, the direction and the data continue unchanged.
- R11: An accepted start clears `done`, `err` and `err_addr` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| rev_first | input | 1 | 0: write forward, read backward; 1: the reverse |
| pattern | input | DW | Base data word for the write pass |
| addr | output | AW | Address shared by both memories |
| wr_en | output | 1 | Write strobe to both memories |
| rd_en | output | 1 | Read strobe to both memories |
| wr_data | output | DW | Data written to both memories |
| rdata_a | input | DW | Read data from the first memory, one cycle after `rd_en` |
| rdata_b | input | DW | Read data from the second memory, one cycle after `rd_en` |
| busy | output | 1 | High from the first write cycle through the final compare cycle |
| done | output | 1 | Run finished, held until the next start |
| err | output | 1 | A mismatch was seen in this run |
| err_addr | output | AW | Address of the first mismatch |

## Verification
The block is run in both direction settings. Comparing the address stream against the two fixed orders separates a forward stepping fault from a backward one, and shows whether the direction choice is applied to the correct pass. A fault-free run checks that `err` stays low and that both memories hold `pattern` XOR address at every location. Runs with the same two corrupted locations in the second memory, under opposite read directions, must report different first-failing addresses; this confirms that the first mismatch is captured and later ones are not. A start pulse in the middle of a pass, and a clean run after a failing one, exercise the ignore rule and the clearing rule.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } bist_st_e;

    // Feedback taps among bits [w-1:1]; bit 0 always feeds back.
    // Each entry realises a primitive trinomial or pentanomial of degree w.
    function automatic logic [15:0] tap_mask(input int w);
        case (w)
            2:       return 16'h0002;
            3:       return 16'h0004;
            4:       return 16'h0008;
            5:       return 16'h0008;
            6:       return 16'h0020;
            7:       return 16'h0040;
            8:       return 16'h0070;
            9:       return 16'h0020;
            10:      return 16'h0080;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/ud_cfsr_next.sv
module ud_cfsr_next #(
    parameter int AW = 4
) (
    input  logic [AW-1:0] cur,
    input  logic          down,
    output logic [AW-1:0] nxt
);
    import mbist_pkg::*;

    localparam logic [15:0]   TAP_ALL = tap_mask(AW);
    localparam logic [AW-1:0] TAPS    = TAP_ALL[AW-1:0];

    logic          fwd_bit;
    logic          back_bit;
    logic [AW-2:0] upper_old;

    always_comb begin
        // forward: shift toward bit 0, new bit into the top
        fwd_bit   = cur[0] ^ (^(cur & TAPS)) ^ ~(|cur[AW-1:1]);
        // backward: rebuild the bit that left at bit 0
        upper_old = cur[AW-2:0];
        back_bit  = cur[AW-1] ^ (^({upper_old, 1'b0} & TAPS)) ^ ~(|upper_old);
        if (down) begin
            nxt = {upper_old, back_bit};
        end else begin
            nxt = {fwd_bit, cur[AW-1:1]};
        end
    end

endmodule

// File: rtl/mutual_cmp.sv
module mutual_cmp #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_vld,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rdata_a,
    input  logic [DW-1:0] rdata_b,
    output logic          err,
    output logic [AW-1:0] err_addr
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] paddr;
        logic          err;
        logic [AW-1:0] eaddr;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d       = cmp_q;
        cmp_d.vld   = rd_vld;
        cmp_d.paddr = rd_addr;
        if (clear) begin
            cmp_d.err   = 1'b0;
            cmp_d.eaddr = '0;
        end else if (cmp_q.vld && (rdata_a != rdata_b) && !cmp_q.err) begin
            cmp_d.err   = 1'b1;
            cmp_d.eaddr = cmp_q.paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign err      = cmp_q.err;
    assign err_addr = cmp_q.eaddr;

endmodule

// File: rtl/dual_mem_bist.sv
module dual_mem_bist #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rev_first,
    input  logic [DW-1:0] pattern,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic          rd_en,
    output logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rdata_a,
    input  logic [DW-1:0] rdata_b,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr
);
    import mbist_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

    typedef struct packed {
        bist_st_e      st;
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic          rev;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          step_down;
    logic [AW-1:0] addr_nxt;
    logic          accept;

    ud_cfsr_next #(.AW(AW)) u_step (
        .cur  (ctl_q.addr),
        .down (step_down),
        .nxt  (addr_nxt)
    );

    always_comb begin
        accept    = start && ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_DONE));
        step_down = (ctl_q.st == ST_READ) ? ~ctl_q.rev : ctl_q.rev;
        ctl_d     = ctl_q;
        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    ctl_d.st   = ST_WRITE;
                    ctl_d.addr = '0;
                    ctl_d.cnt  = '0;
                    ctl_d.rev  = rev_first;
                end
            end
            ST_WRITE: begin
                ctl_d.addr = addr_nxt;
                ctl_d.cnt  = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_IDX) begin
                    ctl_d.st = ST_READ;
                end
            end
            ST_READ: begin
                ctl_d.addr = addr_nxt;
                ctl_d.cnt  = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_IDX) begin
                    ctl_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                ctl_d.st = ST_DONE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, cnt: '0, rev: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr    = ctl_q.addr;
    assign wr_en   = (ctl_q.st == ST_WRITE);
    assign rd_en   = (ctl_q.st == ST_READ);
    assign busy    = wr_en || rd_en || (ctl_q.st == ST_DRAIN);
    assign done    = (ctl_q.st == ST_DONE);
    assign wr_data = pattern ^ DW'(ctl_q.addr);

    mutual_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .rd_vld   (rd_en),
        .rd_addr  (ctl_q.addr),
        .rdata_a  (rdata_a),
        .rdata_b  (rdata_b),
        .err      (err),
        .err_addr (err_addr)
    );

endmodule

// File: rtl/dual_mem_bist_chk.sv
module dual_mem_bist_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] err_addr
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)); // R6

    AST_WRITE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (addr == '0)); // R2

    AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (addr != $past(addr))); // R3

    AST_READ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (addr != $past(addr))); // R4

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && $stable(err_addr))); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en && addr == '0)); // R9

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9

endmodule

bind dual_mem_bist dual_mem_bist_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .done     (done),
    .err      (err),
    .err_addr (err_addr)
);

// File: tb/dual_mem_bist_tb.sv
`timescale 1ns/1ps
module dual_mem_bist_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rev_first = 1'b0;
    logic [DW-1:0] pattern = '0;
    logic [AW-1:0] addr;
    logic          wr_en, rd_en, busy, done, err;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rdata_a = '0;
    logic [DW-1:0] rdata_b = '0;
    logic [AW-1:0] err_addr;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dual_mem_bist #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rev_first(rev_first),
        .pattern(pattern), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rdata_a(rdata_a), .rdata_b(rdata_b),
        .busy(busy), .done(done), .err(err), .err_addr(err_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // memories; the second one may carry corrupted locations
    logic [DW-1:0] mem_a [N];
    logic [DW-1:0] mem_b [N];
    logic [N-1:0]  bad_loc = '0;

    always @(posedge clk) begin
        if (wr_en) begin
            mem_a[addr] <= wr_data;
            mem_b[addr] <= bad_loc[addr] ? (wr_data ^ 8'h01) : wr_data;
        end
        if (rd_en) begin
            rdata_a <= mem_a[addr];
            rdata_b <= mem_b[addr];
        end
    end

    // address orders taken from R3 and R4
    int up_seq [N] = '{0, 8, 12, 14, 15, 7, 11, 5, 10, 13, 6, 3, 9, 4, 2, 1};
    int dn_seq [N];
    initial begin
        dn_seq[0] = 0;
        for (int k = 1; k < N; k++) dn_seq[k] = up_seq[N - k];
    end

    // behavioural reference: 0 idle, 1 write, 2 read, 3 drain, 4 done
    int            ph = 0;
    int            idx = 0;
    bit            m_rev = 0;
    bit            m_err = 0;
    int            m_eaddr = 0;
    bit            m_cvld = 0;
    int            m_caddr = 0;
    bit            seen [N];

    function automatic int m_addr();
        if (ph == 1) return m_rev ? dn_seq[idx] : up_seq[idx];
        if (ph == 2) return m_rev ? up_seq[idx] : dn_seq[idx];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; idx = 0; m_rev = 0; m_err = 0; m_eaddr = 0; m_cvld = 0; m_caddr = 0;
        end else begin
            int cur;
            cur = m_addr();
            if (start && (ph == 0 || ph == 4)) begin
                m_err = 0; m_eaddr = 0;
            end else if (m_cvld && (rdata_a != rdata_b) && !m_err) begin
                m_err = 1; m_eaddr = m_caddr;
            end
            m_cvld  = (ph == 2);
            m_caddr = cur;
            case (ph)
                0, 4: if (start) begin ph = 1; idx = 0; m_rev = rev_first; end
                1: begin idx++; if (idx == N) begin ph = 2; idx = 0; end end
                2: begin idx++; if (idx == N) begin ph = 3; idx = 0; end end
                default: ph = 4;
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(wr_en == (ph == 1), "R2 wr_en", wr_en, (ph == 1));
            chk(rd_en == (ph == 2), "R6 rd_en", rd_en, (ph == 2));
            chk(addr == AW'(m_addr()), "R3,R4,R5 addr", addr, m_addr());
            if (ph == 1) begin
                chk(wr_data == (pattern ^ DW'(m_addr())), "R7 wr_data", wr_data, pattern ^ DW'(m_addr()));
                seen[addr] = 1'b1;
            end
            chk(busy == (ph >= 1 && ph <= 3), "R10 busy", busy, (ph >= 1 && ph <= 3));
            chk(done == (ph == 4), "R9 done", done, (ph == 4));
            chk(err == m_err, "R8 err", err, m_err);
            chk(err_addr == AW'(m_eaddr), "R8 err_addr", err_addr, m_eaddr);
        end
    end

    task automatic run(input bit rv, input logic [DW-1:0] pat, input bit glitch);
        int cyc;
        for (int k = 0; k < N; k++) seen[k] = 1'b0;
        @(negedge clk);
        rev_first = rv; pattern = pat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(wr_en && addr == '0, "R2 first write at zero", {wr_en, addr}, {1'b1, 4'h0});
        chk(!err && !done, "R11 cleared by start", {err, done}, 2'b00);
        chk(err_addr == '0, "R11 err_addr cleared", err_addr, 0);
        cyc = 0;
        while (!done && cyc < 200) begin
            if (glitch && cyc == 5) begin
                start = 1'b1; rev_first = ~rv;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (glitch && cyc == 6) begin
                chk(wr_en && addr == AW'(rv ? dn_seq[6] : up_seq[6]), "R10 start while busy ignored", addr, rv ? dn_seq[6] : up_seq[6]);
            end
        end
        start = 1'b0;
        rev_first = rv;
        chk(cyc == 2 * N + 1, "R9 done latency", cyc, 2 * N + 1);
        begin
            int cnt;
            cnt = 0;
            for (int k = 0; k < N; k++) if (seen[k]) cnt++;
            chk(cnt == N, "R3 every address written", cnt, N);
        end
        repeat (3) @(negedge clk);
        chk(done && !wr_en && !rd_en && addr == '0, "R9 done held quiet", {done, wr_en, rd_en}, 3'b100);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_en && !rd_en && !busy && !done && !err, "R1 reset strobes", {wr_en, rd_en, busy, done, err}, 0);
        chk(addr == '0 && err_addr == '0, "R1 reset addresses", {addr, err_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && addr == '0, "R1 idle after reset", {busy, done}, 0);

        // clean run, forward write, with a mid-run start pulse
        run(1'b0, 8'hA5, 1'b1);
        chk(err == 1'b0, "R8 clean run no error", err, 0);
        for (int k = 0; k < N; k++)
            chk(mem_a[k] == (8'hA5 ^ DW'(k)), "R7 stored word", mem_a[k], 8'hA5 ^ DW'(k));

        // two bad locations, read forward: 9 is met before 2
        bad_loc = '0; bad_loc[9] = 1'b1; bad_loc[2] = 1'b1;
        run(1'b1, 8'h3C, 1'b0);
        chk(err && err_addr == 4'h9, "R5 R8 first fail forward read", err_addr, 9);

        // same faults, read backward: 2 is met before 9
        run(1'b0, 8'h5A, 1'b0);
        chk(err && err_addr == 4'h2, "R4 R8 first fail backward read", err_addr, 2);

        // faults repaired: fresh start clears the old error
        bad_loc = '0;
        run(1'b1, 8'hFF, 1'b0);
        chk(!err && err_addr == '0, "R11 clean run after failing run", {err, err_addr}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule